// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drives the transmit side of a network controller from a ring of descriptors in host memory. Software writes a ring base address, sets the transmit start bit, fills descriptors and hands them over by setting their ownership bit. It then issues a poll demand. The engine walks the ring from its current position. For each descriptor it owns, it reads the control word and the buffer address. It fetches the buffer one 32-bit word at a time and passes its bytes, low byte first, to the MAC over a valid/ready byte stream. When the buffer is done, it writes a completion status over the descriptor's first word, which clears ownership. It keeps going until it reaches a descriptor the host still holds, then suspends until the next poll demand.

A descriptor whose setup bit is set holds an address-filter table instead of frame data. Its bytes never reach the wire. Each group of three words yields one 48-bit filter entry on a separate load port, and entries that are all ones are skipped. A successful setup descriptor is closed with the status word 0x7FFFFFFF.

Top module: `txring_engine`

## Requirements
- R1: After rst_ni is released, tx_state_o reads 0 (stopped), mem_req_o and tx_valid_o are low, and flt_valid_o is low.
- R2: Register write address 0 is the mode register. Writing it with bit 13 set takes a stopped engine to suspended (tx_state_o = 6) and reloads the current descriptor pointer from the ring base (address 2, bits AW-1:4 kept, low 4 bits forced to zero). The engine does not touch memory while suspended.
- R3: A write to address 1 with bit 0 set is a poll demand. It makes a suspended engine read the status word at the current pointer. A poll write with bit 0 clear, or any poll while stopped, causes no memory access.
- R4: A descriptor is taken only if bit 31 of its status word is set. A status word with bit 31 clear returns the engine to suspended and leaves that descriptor unchanged.
- R5: Descriptor words sit at pointer+0 (status), +4 (control) and +8 (buffer address). In the control word, bit 30 is last segment, bit 29 is first segment, bit 27 is setup, bit 25 is end of ring, and bits LW-1:0 give the byte length. Exactly that many bytes go out on the stream, in ascending address order with the low byte of each word first. tx_first_o marks byte 0 when bit 29 is set, and tx_last_o marks the final byte when bit 30 is set.
- R6: At completion the engine writes 0x00000000 to the status word. If tx_err_i was high at the handshake of any byte of the descriptor, it writes 0x00008000 instead (bit 15, error summary).
- R7: After a descriptor closes, the pointer advances by 16 bytes, or returns to the ring base if bit 25 was set. The engine then reads the next status word without needing another poll.
- R8: A setup descriptor sends no bytes on the stream. Every 12 bytes form one entry whose address is the low 16 bits of three words, low byte first (bits 7:0 hold the first address byte). An entry whose 48 bits are all ones is not emitted, but it still advances flt_idx_o. The status is written back as 0x7FFFFFFF.
- R9: Clearing bit 13 in the mode register lets the current descriptor finish and write back its status, then puts the engine in the stopped state (0).
- R10: A write to address 3 with bit 0 set is a soft reset. It aborts any transfer, and on the next cycle tx_state_o is 0, tx_valid_o and mem_req_o are low, and the start bit is cleared.
- R11: mem_req_o stays high with a stable address and direction until mem_ack_i. tx_data_o stays stable while tx_valid_o is high and tx_ready_i is low.
- R12: A descriptor with length 0 sends no bytes and is closed with status 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mode, 1 poll, 2 ring base, 3 bus control |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Byte valid toward the MAC |
| tx_data_o | output | 8 | Byte value |
| tx_first_o | output | 1 | Byte is the first of a frame |
| tx_last_o | output | 1 | Byte is the last of a frame |
| tx_ready_i | input | 1 | MAC accepts the byte |
| tx_err_i | input | 1 | MAC reports a failure for the accepted byte |
| flt_valid_o | output | 1 | Filter entry valid (one cycle) |
| flt_idx_o | output | FLT_IW | Filter entry index |
| flt_addr_o | output | 48 | Filter address, first byte in bits 7:0 |
| tx_state_o | output | 3 | Process state: 0 stopped, 1 fetching, 3 moving data, 7 closing, 6 suspended |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, an 11-bit length field and a 16-entry filter table. With these values a single setup descriptor of 192 bytes fills the whole table, so both skipped and emitted entries appear in one frame. The four-slot ring with end of ring on the last slot is long enough to show wraparound to the base and continuation until a descriptor is found that the engine does not own. Random-looking stall cycles on the MAC side, a flagged MAC error, a zero-length descriptor, a stop during a frame and a soft reset during a frame cover the ordering cases.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int OWN_BIT   = 31;
  localparam int LS_BIT    = 30;
  localparam int FS_BIT    = 29;
  localparam int SET_BIT   = 27;
  localparam int EOR_BIT   = 25;
  localparam int START_BIT = 13;
  localparam int SWR_BIT   = 0;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_POLL = 2'd1;
  localparam logic [1:0] REG_BASE = 2'd2;
  localparam logic [1:0] REG_BUS  = 2'd3;

  localparam logic [31:0] STS_OK    = 32'h0000_0000;
  localparam logic [31:0] STS_ERR   = 32'h0000_8000;
  localparam logic [31:0] STS_SETUP = 32'h7FFF_FFFF;

  localparam logic [2:0] PS_STOP  = 3'd0;
  localparam logic [2:0] PS_FETCH = 3'd1;
  localparam logic [2:0] PS_XFER  = 3'd3;
  localparam logic [2:0] PS_SUSP  = 3'd6;
  localparam logic [2:0] PS_CLOSE = 3'd7;

  typedef enum logic [2:0] {
    S_STOP, S_IDLE, S_RD_STS, S_RD_CTL, S_RD_BUF, S_RD_DAT, S_SEND, S_WB
  } fsm_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic          start_o,
  output logic [AW-1:0] base_o,
  output logic          poll_o,
  output logic          srst_o
);
  assign poll_o = we_i && addr_i == REG_POLL && wdata_i[0];
  assign srst_o = we_i && addr_i == REG_BUS && wdata_i[SWR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      base_o  <= '0;
    end else if (srst_o) begin
      start_o <= 1'b0;
    end else if (we_i) begin
      if (addr_i == REG_MODE) start_o <= wdata_i[START_BIT];
      if (addr_i == REG_BASE) base_o  <= {wdata_i[AW-1:4], 4'b0000};
    end
  end

  AST_SRST_CLEARS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> !start_o) else $error("start survives soft reset"); // R10
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          poll_i,
  input  logic          srst_i,
  input  logic [AW-1:0] base_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          ld_o,
  output logic [31:0]   word_o,
  output logic [2:0]    nbytes_o,
  output logic          first_o,
  output logic          last_o,
  output logic          setup_o,
  output logic          setup_start_o,
  input  logic          done_i,
  input  logic          err_i,
  output logic [2:0]    state_o
);
  localparam logic [AW-1:0] DESC_STRIDE = AW'(16);
  localparam logic [LW-1:0] WORD_BYTES  = LW'(4);

  fsm_e          state_q;
  logic [AW-1:0] ptr_q, buf_q, off_q;
  logic [LW-1:0] rem_q;
  logic [31:0]   ctl_q, word_q;
  logic          err_q, ld_q;
  logic          last_word;

  assign last_word = rem_q <= WORD_BYTES;
  assign nbytes_o  = last_word ? rem_q[2:0] : 3'd4;
  assign first_o   = ctl_q[FS_BIT] && off_q == '0;
  assign last_o    = ctl_q[LS_BIT] && last_word;
  assign setup_o   = ctl_q[SET_BIT];
  assign ld_o      = ld_q;
  assign word_o    = word_q;
  assign setup_start_o = state_q == S_RD_BUF && mem_ack_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q;
    mem_wdata_o = ctl_q[SET_BIT] ? STS_SETUP : (err_q ? STS_ERR : STS_OK);
    unique case (state_q)
      S_RD_STS: mem_req_o = 1'b1;
      S_RD_CTL: begin mem_req_o = 1'b1; mem_addr_o = ptr_q + AW'(4); end
      S_RD_BUF: begin mem_req_o = 1'b1; mem_addr_o = ptr_q + AW'(8); end
      S_RD_DAT: begin mem_req_o = 1'b1; mem_addr_o = buf_q + off_q; end
      S_WB:     begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default:  ;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_STOP:                      state_o = PS_STOP;
      S_IDLE:                      state_o = PS_SUSP;
      S_RD_STS, S_RD_CTL, S_RD_BUF: state_o = PS_FETCH;
      S_RD_DAT, S_SEND:            state_o = PS_XFER;
      default:                     state_o = PS_CLOSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_STOP;
      ptr_q   <= '0;
      buf_q   <= '0;
      off_q   <= '0;
      rem_q   <= '0;
      ctl_q   <= '0;
      word_q  <= '0;
      err_q   <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      if (srst_i) begin
        state_q <= S_STOP;
      end else begin
        unique case (state_q)
          S_STOP: if (start_i) begin
            ptr_q   <= base_i;
            state_q <= S_IDLE;
          end
          S_IDLE: begin
            if (!start_i)    state_q <= S_STOP;
            else if (poll_i) state_q <= S_RD_STS;
          end
          S_RD_STS: if (mem_ack_i)
            state_q <= mem_rdata_i[OWN_BIT] ? S_RD_CTL : S_IDLE;
          S_RD_CTL: if (mem_ack_i) begin
            ctl_q   <= mem_rdata_i;
            rem_q   <= mem_rdata_i[LW-1:0];
            state_q <= S_RD_BUF;
          end
          S_RD_BUF: if (mem_ack_i) begin
            buf_q   <= mem_rdata_i[AW-1:0];
            off_q   <= '0;
            err_q   <= 1'b0;
            state_q <= (rem_q == '0) ? S_WB : S_RD_DAT;
          end
          S_RD_DAT: if (mem_ack_i) begin
            word_q  <= mem_rdata_i;
            ld_q    <= 1'b1;
            state_q <= S_SEND;
          end
          S_SEND: begin
            if (err_i) err_q <= 1'b1;
            if (done_i) begin
              rem_q   <= last_word ? '0 : rem_q - WORD_BYTES;
              off_q   <= off_q + AW'(4);
              state_q <= last_word ? S_WB : S_RD_DAT;
            end
          end
          S_WB: if (mem_ack_i) begin
            ptr_q   <= ctl_q[EOR_BIT] ? base_i : ptr_q + DESC_STRIDE;
            state_q <= start_i ? S_RD_STS : S_STOP;
          end
          default: state_q <= S_STOP;
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !srst_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)))
    else $error("request dropped or changed before ack"); // R11
  AST_SRST_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (state_o == PS_STOP && !mem_req_o)) else $error("soft reset did not halt"); // R10
  AST_POLL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == PS_SUSP && !poll_i) |=> state_o != PS_FETCH) else $error("fetch without poll"); // R3
endmodule

// File: rtl/txr_serializer.sv
module txr_serializer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        ld_i,
  input  logic [31:0] word_i,
  input  logic [2:0]  nbytes_i,
  input  logic        first_i,
  input  logic        last_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_first_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  input  logic        tx_err_i,
  output logic        done_o,
  output logic        err_o
);
  logic        busy_q, first_q, last_q;
  logic [31:0] word_q;
  logic [2:0]  nb_q;
  logic [1:0]  idx_q;
  logic        fin;

  assign fin        = {1'b0, idx_q} == nb_q - 3'd1;
  assign tx_valid_o = busy_q;
  assign tx_data_o  = word_q[8*idx_q +: 8];
  assign tx_first_o = busy_q && first_q && idx_q == 2'd0;
  assign tx_last_o  = busy_q && last_q && fin;
  assign done_o     = busy_q && tx_ready_i && fin;
  assign err_o      = busy_q && tx_ready_i && tx_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      word_q  <= '0;
      nb_q    <= '0;
      idx_q   <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
    end else if (ld_i) begin
      busy_q  <= 1'b1;
      word_q  <= word_i;
      nb_q    <= nbytes_i;
      first_q <= first_i;
      last_q  <= last_i;
      idx_q   <= '0;
    end else if (busy_q && tx_ready_i) begin
      if (fin) busy_q <= 1'b0;
      idx_q <= idx_q + 2'd1;
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !clr_i) |=> (tx_valid_o && $stable(tx_data_o)))
    else $error("stream byte changed while stalled"); // R11
  AST_LD_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> !tx_valid_o) else $error("word loaded over busy stream"); // R5
endmodule

// File: rtl/txr_setup_parse.sv
module txr_setup_parse #(
  parameter int FLT_N  = 16,
  parameter int FLT_IW = $clog2(FLT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [31:0]       word_i,
  output logic              done_o,
  output logic              flt_valid_o,
  output logic [FLT_IW-1:0] flt_idx_o,
  output logic [47:0]       flt_addr_o
);
  logic [1:0]        wsel_q;
  logic [15:0]       h0_q, h1_q;
  logic [FLT_IW-1:0] ent_q;
  logic [47:0]       entry;

  assign entry = {word_i[15:0], h1_q, h0_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsel_q      <= '0;
      h0_q        <= '0;
      h1_q        <= '0;
      ent_q       <= '0;
      done_o      <= 1'b0;
      flt_valid_o <= 1'b0;
      flt_idx_o   <= '0;
      flt_addr_o  <= '0;
    end else begin
      done_o      <= ld_i && !clr_i;
      flt_valid_o <= 1'b0;
      if (clr_i) begin
        wsel_q <= '0;
        ent_q  <= '0;
      end else if (ld_i) begin
        unique case (wsel_q)
          2'd0: begin h0_q <= word_i[15:0]; wsel_q <= 2'd1; end
          2'd1: begin h1_q <= word_i[15:0]; wsel_q <= 2'd2; end
          default: begin
            wsel_q      <= 2'd0;
            ent_q       <= ent_q + FLT_IW'(1);
            flt_idx_o   <= ent_q;
            flt_addr_o  <= entry;
            flt_valid_o <= entry != {48{1'b1}};
          end
        endcase
      end
    end
  end

  AST_FLT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_o |-> $past(ld_i)) else $error("filter entry without a loaded word"); // R8
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 11,
  parameter int FLT_N  = 16,
  parameter int FLT_IW = $clog2(FLT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_first_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  input  logic              tx_err_i,
  output logic              flt_valid_o,
  output logic [FLT_IW-1:0] flt_idx_o,
  output logic [47:0]       flt_addr_o,
  output logic [2:0]        tx_state_o
);
  logic          start, poll, srst;
  logic [AW-1:0] base;
  logic          ld, setup, setup_start, first, last;
  logic [31:0]   word;
  logic [2:0]    nbytes;
  logic          ser_done, ser_err, par_done;

  txr_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .start_o(start), .base_o(base), .poll_o(poll), .srst_o(srst)
  );

  txr_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i(start), .poll_i(poll), .srst_i(srst), .base_i(base),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .ld_o(ld), .word_o(word), .nbytes_o(nbytes), .first_o(first), .last_o(last),
    .setup_o(setup), .setup_start_o(setup_start),
    .done_i(ser_done | par_done), .err_i(ser_err), .state_o(tx_state_o)
  );

  txr_serializer u_ser (
    .clk_i, .rst_ni, .clr_i(srst),
    .ld_i(ld && !setup), .word_i(word), .nbytes_i(nbytes),
    .first_i(first), .last_i(last),
    .tx_valid_o, .tx_data_o, .tx_first_o, .tx_last_o, .tx_ready_i, .tx_err_i,
    .done_o(ser_done), .err_o(ser_err)
  );

  txr_setup_parse #(.FLT_N(FLT_N), .FLT_IW(FLT_IW)) u_parse (
    .clk_i, .rst_ni, .clr_i(srst || setup_start),
    .ld_i(ld && setup), .word_i(word),
    .done_o(par_done), .flt_valid_o, .flt_idx_o, .flt_addr_o
  );

  AST_SETUP_OFF_WIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_o |-> !tx_valid_o) else $error("setup data on the wire"); // R8
endmodule

// File: tb/txring_engine_tb_top.sv
module txring_engine_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUF0 = 32'h400, BUF1 = 32'h440, BUF2 = 32'h480, BUF3 = 32'h4C0, BUFS = 32'h600;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_first, tx_last, tx_ready, tx_err;
  logic [7:0]  tx_data;
  logic        flt_valid;
  logic [3:0]  flt_idx;
  logic [47:0] flt_addr;
  logic [2:0]  tx_state;

  txring_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_first_o(tx_first), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .tx_err_i(tx_err),
    .flt_valid_o(flt_valid), .flt_idx_o(flt_idx), .flt_addr_o(flt_addr), .tx_state_o(tx_state)
  );

  // memory model: single driver process for the array
  logic [31:0] mem [1024];
  logic        tb_we = 1'b0;
  logic [31:0] tb_wa = '0, tb_wd = '0;
  int          ack_n = 0;
  initial mem_ack = 1'b0;
  initial mem_rdata = '0;
  always @(posedge clk) begin
    mem_ack <= mem_req & ~mem_ack;
    if (tb_we) mem[tb_wa[11:2]] <= tb_wd;
    else if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[11:2]];
      ack_n <= ack_n + 1;
    end
  end

  // stream sink
  logic       bp_en = 1'b0, err_arm = 1'b0;
  logic [3:0] bp_cnt = '0;
  always @(negedge clk) bp_cnt <= bp_cnt + 4'd1;
  assign tx_ready = !bp_en || (bp_cnt[0] ^ bp_cnt[2]);
  assign tx_err = err_arm;

  logic [7:0]  cap [256];
  int          cap_n = 0, first_n = 0, last_pos = -1;
  logic [47:0] fcap_a [16];
  logic [3:0]  fcap_i [16];
  int          flt_n = 0;
  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      cap[cap_n[7:0]] <= tx_data;
      if (tx_first) first_n <= first_n + 1;
      if (tx_last) last_pos <= cap_n;
      cap_n <= cap_n + 1;
    end
    if (flt_valid) begin
      fcap_a[flt_n[3:0]] <= flt_addr;
      fcap_i[flt_n[3:0]] <= flt_idx;
      flt_n <= flt_n + 1;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_b(input logic [31:0] b, input int k);
    return 8'(b[9:2] * 5 + k * 3 + 1);
  endfunction

  function automatic logic [31:0] ctl(input bit ls, input bit fs, input bit st, input bit eor, input int len);
    return {1'b0, ls, fs, 1'b0, st, 1'b0, eor, 14'd0, 11'(len)};
  endfunction

  task automatic mem_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic fill_buf(input logic [31:0] b, input int len);
    for (int w = 0; w < (len + 3) / 4; w++)
      mem_wr(b + 32'(4 * w), {exp_b(b, 4*w+3), exp_b(b, 4*w+2), exp_b(b, 4*w+1), exp_b(b, 4*w)});
  endtask

  task automatic set_desc(input int slot, input bit own, input logic [31:0] c, input logic [31:0] b);
    logic [31:0] d = BASE + 32'(16 * slot);
    mem_wr(d, own ? 32'h8000_0000 : 32'h0000_1234);
    mem_wr(d + 4, c);
    mem_wr(d + 8, b);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_state(input logic [2:0] s);
    int n = 0;
    @(negedge clk);
    while (tx_state != s && n < 3000) begin @(negedge clk); n++; end
    chk(tx_state == s, "wait state", 64'(tx_state), 64'(s));
  endtask

  task automatic cmp_bytes(input string req, input int from, input logic [31:0] b, input int len);
    for (int k = 0; k < len; k++)
      chk(cap[8'(from + k)] == exp_b(b, k), req, 64'(cap[8'(from + k)]), 64'(exp_b(b, k)));
  endtask

  function automatic logic [31:0] sts(input int slot);
    return mem[10'((BASE + 32'(16 * slot)) >> 2)];
  endfunction

  task automatic t_reset();
    chk(tx_state == 3'd0, "R1 state", 64'(tx_state), 0);
    chk(!mem_req && !tx_valid && !flt_valid, "R1 outputs", {mem_req, tx_valid, flt_valid}, 0);
  endtask

  task automatic t_start();
    int a0;
    reg_wr(2'd2, BASE);
    reg_wr(2'd0, 32'h2000);
    a0 = ack_n;
    repeat (10) @(negedge clk);
    chk(tx_state == 3'd6, "R2 suspended", 64'(tx_state), 6);
    chk(ack_n == a0, "R2 no access while suspended", 64'(ack_n), 64'(a0));
    reg_wr(2'd1, 32'h0000_0002);
    repeat (10) @(negedge clk);
    chk(ack_n == a0, "R3 poll bit0 clear ignored", 64'(ack_n), 64'(a0));
  endtask

  task automatic t_frame();
    int c0 = cap_n, f0 = first_n;
    fill_buf(BUF0, 10);
    set_desc(0, 1, ctl(1, 1, 0, 0, 10), BUF0);
    set_desc(1, 0, ctl(1, 1, 0, 0, 6), BUF1);
    bp_en = 1'b1;
    reg_wr(2'd1, 32'h1);
    wait_state(3'd6);
    bp_en = 1'b0;
    chk(cap_n - c0 == 10, "R5 byte count", 64'(cap_n - c0), 10);
    cmp_bytes("R5 byte order under stalls R11", c0, BUF0, 10);
    chk(first_n - f0 == 1, "R5 first flag", 64'(first_n - f0), 1);
    chk(last_pos == c0 + 9, "R5 last flag", 64'(last_pos), 64'(c0 + 9));
    chk(sts(0) == 32'h0, "R6 ok status", 64'(sts(0)), 0);
    chk(sts(1) == 32'h1234, "R4 not-owned descriptor untouched", 64'(sts(1)), 64'h1234);
  endtask

  task automatic t_error();
    int c0 = cap_n;
    fill_buf(BUF1, 6);
    set_desc(1, 1, ctl(1, 1, 0, 0, 6), BUF1);
    mem_wr(BASE + 32, 32'h0);
    err_arm = 1'b1;
    reg_wr(2'd1, 32'h1);
    wait_state(3'd6);
    err_arm = 1'b0;
    chk(cap_n - c0 == 6, "R6 error frame bytes", 64'(cap_n - c0), 6);
    chk(sts(1) == 32'h8000, "R6 error summary", 64'(sts(1)), 64'h8000);
  endtask

  task automatic t_ring();
    int c0 = cap_n;
    fill_buf(BUF3, 5);
    fill_buf(BUF0, 3);
    set_desc(2, 1, ctl(1, 1, 0, 0, 0), BUF2);
    set_desc(3, 1, ctl(1, 1, 0, 1, 5), BUF3);
    set_desc(0, 1, ctl(1, 1, 0, 0, 3), BUF0);
    reg_wr(2'd1, 32'h1);
    wait_state(3'd6);
    chk(sts(2) == 32'h0, "R12 zero-length status", 64'(sts(2)), 0);
    chk(cap_n - c0 == 8, "R12 R7 byte count", 64'(cap_n - c0), 8);
    cmp_bytes("R7 slot3 bytes", c0, BUF3, 5);
    cmp_bytes("R7 wrap to base", c0 + 5, BUF0, 3);
    chk(sts(3) == 32'h0 && sts(0) == 32'h0, "R7 statuses", {sts(3), sts(0)}, 0);
  endtask

  task automatic t_setup();
    int c0 = cap_n, n0 = flt_n;
    for (int w = 0; w < 48; w++) mem_wr(BUFS + 32'(4 * w), 32'hFFFF_FFFF);
    mem_wr(BUFS + 0, 32'hABCD_2211);
    mem_wr(BUFS + 4, 32'hABCD_4433);
    mem_wr(BUFS + 8, 32'hABCD_6655);
    mem_wr(BUFS + 24, 32'h0000_0201);
    mem_wr(BUFS + 28, 32'h0000_0403);
    mem_wr(BUFS + 32, 32'h0000_0605);
    set_desc(1, 1, ctl(0, 0, 1, 0, 192), BUFS);
    reg_wr(2'd1, 32'h1);
    wait_state(3'd6);
    chk(cap_n == c0, "R8 nothing on wire", 64'(cap_n - c0), 0);
    chk(flt_n - n0 == 2, "R8 entry count", 64'(flt_n - n0), 2);
    chk(fcap_a[4'(n0)] == 48'h6655_4433_2211 && fcap_i[4'(n0)] == 4'd0, "R8 entry 0",
        {fcap_i[4'(n0)], fcap_a[4'(n0)]}, 64'h0_6655_4433_2211);
    chk(fcap_a[4'(n0+1)] == 48'h0605_0403_0201 && fcap_i[4'(n0+1)] == 4'd2, "R8 entry 2 after skip",
        {fcap_i[4'(n0+1)], fcap_a[4'(n0+1)]}, 64'h2_0605_0403_0201);
    chk(sts(1) == 32'h7FFF_FFFF, "R8 setup status", 64'(sts(1)), 64'h7FFF_FFFF);
  endtask

  task automatic t_stop();
    int c0, a0;
    fill_buf(BUF2, 8);
    set_desc(2, 1, ctl(1, 1, 0, 0, 8), BUF2);
    c0 = cap_n;
    reg_wr(2'd1, 32'h1);
    while (!tx_valid) @(negedge clk);
    reg_wr(2'd0, 32'h0);
    wait_state(3'd0);
    chk(cap_n - c0 == 8, "R9 frame finished", 64'(cap_n - c0), 8);
    chk(sts(2) == 32'h0, "R9 status written", 64'(sts(2)), 0);
    fill_buf(BUF0, 4);
    set_desc(0, 1, ctl(1, 1, 0, 0, 4), BUF0);
    a0 = ack_n;
    reg_wr(2'd1, 32'h1);
    repeat (8) @(negedge clk);
    chk(ack_n == a0 && tx_state == 3'd0, "R3 poll while stopped", 64'(ack_n - a0), 0);
    c0 = cap_n;
    reg_wr(2'd0, 32'h2000);
    reg_wr(2'd1, 32'h1);
    wait_state(3'd6);
    chk(cap_n - c0 == 4, "R2 R9 restart at base", 64'(cap_n - c0), 4);
    cmp_bytes("R2 restart bytes", c0, BUF0, 4);
  endtask

  task automatic t_srst();
    int a0;
    fill_buf(BUF1, 40);
    set_desc(1, 1, ctl(1, 1, 0, 0, 40), BUF1);
    reg_wr(2'd1, 32'h1);
    while (!tx_valid) @(negedge clk);
    reg_wr(2'd3, 32'h1);
    chk(tx_state == 3'd0 && !tx_valid && !mem_req, "R10 abort", {tx_state, tx_valid, mem_req}, 0);
    a0 = ack_n;
    reg_wr(2'd1, 32'h1);
    repeat (10) @(negedge clk);
    chk(ack_n == a0 && tx_state == 3'd0, "R10 start cleared", 64'(ack_n - a0), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_frame();
    t_error();
    t_ring();
    t_setup();
    t_stop();
    t_srst();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule